// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Bus Slave

This block is the slave side of an SMBus/I2C-style two-wire link. It joins the bus to a small internal register bank through an 8-bit pointer. SCL and SDA are sampled on the system clock. Start and stop conditions are found from the sampled lines. After a start, the block takes in a 7-bit device address and a direction bit. It acknowledges only its own address. SDA is driven open-drain: `sda_oe_o` high means the pad pulls the line low. The block never stretches the clock and never takes part in arbitration.

In a write transfer, the first data byte always goes into the pointer. A second byte, when one is sent, lands in the control register that the pointer selects. Later bytes are refused. In a read transfer, the block sends back one byte from whatever register the pointer already selects. No pointer write is needed first.

The register bank has two separate address maps. Control registers are written at one range of addresses and read back at another range. A row of status bytes taken from an input port can be read at a third range. The control register contents come out on a flat port, so logic beside the block can use them directly. The bus is the only data path into or out of the block, so there is no streaming handshake. A register write takes effect in one clock, with no back-pressure.

Top module: `smbus_ptr_slave`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A stop releases SDA and returns the block to idle. Bytes clocked after a stop and before the next start get no acknowledge.
- R2: After a start, eight bits are shifted in on rising SCL, MSB first. The first seven are the device address (default 0x4C). The eighth is the direction: 0 for write, 1 for read.
- R3: When the address matches, `sda_oe_o` is raised from the SCL fall after the eighth bit until the SCL fall after the ninth clock. Any other address gets no acknowledge, and SDA is not driven again until the next start.
- R4: In a write transfer, the first data byte is always loaded into the pointer and is acknowledged. This happens even when the pointer already holds that value.
- R5: The second data byte of a write is acknowledged and stored in control register k, where the pointer equals WR_BASE+k. The write map is WR_BASE..WR_BASE+NREG-1, which is 0x10..0x13 by default.
- R6: A read transfer sends, MSB first, the read-map byte at the pointer. `sda_oe_o` equals the inverse of each bit while SCL is low and high for that bit. The read map is as follows. RD_BASE+k (0x00..0x03) returns control register k. STAT_BASE+j (0x08..0x09) returns `stat_i[8j+7:8j]`. Every other address returns 0xFF.
- R7: The pointer resets to 0x00 and keeps its value across transfers. A read needs no pointer write beforehand.
- R8: A second write byte changes nothing when the pointer is outside the write map, for example at a read-map address. Write-map addresses read back as 0xFF.
- R9: A repeated start at any point aborts the transfer in progress. A byte that is partly received is dropped, and address reception starts again.
- R10: In a write, the third and later data bytes get no acknowledge and leave the control registers unchanged.
- R11: After the eight data bits of a read, SDA is released for the ninth clock, whether the master acknowledges or not. It stays released until the next start.
- R12: After reset, `sda_oe_o` is 0 and every control register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| stat_i | input | NSTAT*8 | Status bytes readable through the read map |
| ctl_regs_o | output | NREG*8 | Control register contents, register k in bits [8k+7:8k] |

## Verification
The main path is tried with four transfer shapes:
- a full write of two bytes;
- a write that sets only the pointer and is followed by a read;
- a read that reuses the old pointer;
- an over-long write of three bytes.

Together these separate a byte stored in the pointer from a byte stored in a register, and show that the pointer survives a stop. Reads are aimed at each part of the read map: a control register, a status byte and a write-map address. This shows that the two maps are decoded separately. A foreign device address, bytes clocked with no start, and a byte cut off by a repeated start each show that the block stays silent and leaves its state alone when it is not properly addressed.

// File: rtl/smbus_ptr_pkg.sv
package smbus_ptr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_SKIP
  } link_state_t;

  // True when addr falls inside [base, base+count)
  function automatic logic in_window(input logic [7:0] addr, input int base, input int count);
    return (int'(addr) >= base) && (int'(addr) < base + count);
  endfunction

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], line_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  // A rising level must have been a high pad value two samples earlier
  AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $past(line_i, STAGES)) else $error("sync lag"); // R1

endmodule

// File: rtl/smbus_reg_bank.sv
module smbus_reg_bank
  import smbus_ptr_pkg::*;
#(
  parameter int NREG      = 4,
  parameter int NSTAT     = 2,
  parameter int WR_BASE   = 16,
  parameter int RD_BASE   = 0,
  parameter int STAT_BASE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [7:0]         rd_addr_i,
  input  logic [NSTAT*8-1:0] stat_i,
  output logic [7:0]         rd_data_o,
  output logic [NREG*8-1:0]  regs_o
);
  logic [7:0] bank_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[k] <= 8'h00;
      else if (wr_en_i && wr_addr_i == 8'(WR_BASE + k))
        bank_q[k] <= wr_data_i;
    end
    assign regs_o[8*k +: 8] = bank_q[k];
  end

  always_comb begin
    rd_data_o = 8'hFF;
    for (int k = 0; k < NREG; k++)
      if (rd_addr_i == 8'(RD_BASE + k)) rd_data_o = bank_q[k];
    for (int j = 0; j < NSTAT; j++)
      if (rd_addr_i == 8'(STAT_BASE + j)) rd_data_o = stat_i[8*j +: 8];
  end

  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !in_window(wr_addr_i, WR_BASE, NREG)) |=> $stable(regs_o))
    else $error("write outside map changed a register"); // R8

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && in_window(wr_addr_i, WR_BASE, NREG)) |=>
      regs_o[8*(int'($past(wr_addr_i)) - WR_BASE) +: 8] == $past(wr_data_i))
    else $error("write did not land"); // R5

endmodule

// File: rtl/smbus_link_fsm.sv
module smbus_link_fsm
  import smbus_ptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h4C,
  parameter logic [7:0] PTR_RESET = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_lvl_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic [7:0] ptr_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_data_o
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  link_state_t state_q;
  logic [3:0]  bit_cnt_q;
  logic [7:0]  shift_q;
  logic [1:0]  byte_idx_q;
  logic        is_read_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      byte_idx_q <= '0;
      is_read_q  <= 1'b0;
      sda_oe_o   <= 1'b0;
      ptr_o      <= PTR_RESET;
      wr_stb_o   <= 1'b0;
      wr_data_o  <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_i) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        sda_oe_o   <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              shift_q   <= {shift_q[6:0], sda_lvl_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == BITS_PER_BYTE) begin
              bit_cnt_q <= '0;
              if (shift_q[7:1] == DEV_ADDR) begin
                is_read_q <= shift_q[0];
                sda_oe_o  <= 1'b1;
                state_q   <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_rise_i) begin
              bit_cnt_q <= 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd1) begin
              bit_cnt_q <= '0;
              if (is_read_q) begin
                shift_q  <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                state_q  <= ST_RD_BYTE;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_BYTE: begin
            if (scl_rise_i) begin
              shift_q   <= {shift_q[6:0], sda_lvl_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == BITS_PER_BYTE) begin
              bit_cnt_q <= '0;
              unique case (byte_idx_q)
                2'd0: begin
                  ptr_o      <= shift_q;
                  sda_oe_o   <= 1'b1;
                  byte_idx_q <= 2'd1;
                  state_q    <= ST_WR_ACK;
                end
                2'd1: begin
                  wr_stb_o   <= 1'b1;
                  wr_data_o  <= shift_q;
                  sda_oe_o   <= 1'b1;
                  byte_idx_q <= 2'd2;
                  state_q    <= ST_WR_ACK;
                end
                default: state_q <= ST_SKIP;
              endcase
            end
          end
          ST_WR_ACK: begin
            if (scl_rise_i) begin
              bit_cnt_q <= 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd1) begin
              bit_cnt_q <= '0;
              sda_oe_o  <= 1'b0;
              state_q   <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == BITS_PER_BYTE) begin
              bit_cnt_q <= '0;
              sda_oe_o  <= 1'b0;
              state_q   <= ST_RD_ACK;
            end else if (scl_fall_i && bit_cnt_q != 4'd0) begin
              shift_q  <= {shift_q[6:0], 1'b0};
              sda_oe_o <= ~shift_q[6];
            end
          end
          ST_RD_ACK: begin
            // the master's answer is sampled and dropped: one byte per read
            if (scl_rise_i) state_q <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  AST_QUIET_WHEN_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_SKIP || state_q == ST_RD_ACK) |-> !sda_oe_o)
    else $error("driving while unselected"); // R3

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!sda_oe_o && state_q == ST_IDLE)) else $error("stop ignored"); // R1

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == ST_ADDR && bit_cnt_q == 4'd0)) else $error("start ignored"); // R9

  AST_ONE_WRITE_PER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> (!wr_stb_o && byte_idx_q == 2'd2)) else $error("extra write"); // R10

endmodule

// File: rtl/smbus_ptr_slave.sv
module smbus_ptr_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h4C,
  parameter int         NREG      = 4,
  parameter int         NSTAT     = 2,
  parameter int         WR_BASE   = 16,
  parameter int         RD_BASE   = 0,
  parameter int         STAT_BASE = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [NSTAT*8-1:0] stat_i,
  output logic [NREG*8-1:0]  ctl_regs_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic [7:0] ptr, wr_data, rd_data;
  logic wr_stb;

  smbus_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;

  smbus_link_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_RESET(8'h00)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_lvl_i(sda_lvl),
    .start_i(start_det), .stop_i(stop_det), .rd_data_i(rd_data),
    .sda_oe_o(sda_oe_o), .ptr_o(ptr), .wr_stb_o(wr_stb), .wr_data_o(wr_data));

  smbus_reg_bank #(
    .NREG(NREG), .NSTAT(NSTAT), .WR_BASE(WR_BASE),
    .RD_BASE(RD_BASE), .STAT_BASE(STAT_BASE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_stb), .wr_addr_i(ptr),
    .wr_data_i(wr_data), .rd_addr_i(ptr), .stat_i(stat_i),
    .rd_data_o(rd_data), .regs_o(ctl_regs_o));

endmodule

// File: tb/smbus_ptr_slave_tb_top.sv
module smbus_ptr_slave_tb_top;
  localparam int Q = 8;  // quarter bit in clocks
  localparam logic [6:0] MY = 7'h4C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [15:0] stat = 16'h0;
  logic [31:0] regs;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t exp_q[$];
  logic [7:0] obs_q[$];

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  smbus_ptr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .stat_i(stat), .ctl_regs_o(regs));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    acked = ~sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
      b = {b[6:0], sda_bus}; tick(Q); m_scl = 1'b0; tick(Q);
    end
    send_bit(nack);
    m_sda = 1'b1;
  endtask

  // Driver: two-byte or pointer-only write
  task automatic do_write(input logic [7:0] p, input bit with_data, input logic [7:0] d,
                          input string req);
    logic a;
    bus_start();
    send_byte({MY, 1'b0}, a); chk({req, " addr ack R3"}, 32'(a), 32'd1);
    send_byte(p, a);          chk({req, " ptr ack R4"}, 32'(a), 32'd1);
    if (with_data) begin
      send_byte(d, a);        chk({req, " data ack R5"}, 32'(a), 32'd1);
    end
    bus_stop();
  endtask

  // Driver: read with expected value into scoreboard
  task automatic do_read(input logic [7:0] exp, input string req);
    logic a;
    logic [7:0] b;
    exp_q.push_back('{val: exp, req: req});
    bus_start();
    send_byte({MY, 1'b1}, a); chk({req, " read addr ack R2"}, 32'(a), 32'd1);
    recv_byte(1'b1, b);
    obs_q.push_back(b);
    chk("R11 released after nack", 32'(sda_oe), 32'd0);
    bus_stop();
  endtask

  // Monitor: compare each observed read byte against the next expectation
  initial begin
    forever begin
      wait (obs_q.size() != 0 && exp_q.size() != 0);
      begin
        exp_t e;
        logic [7:0] o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        chk({e.req, " read data"}, 32'(o), 32'(e.val));
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    tick(5); rst_n = 1'b1; tick(5);
    chk("R12 oe at reset", 32'(sda_oe), 32'd0);
    chk("R12 regs at reset", regs, 32'h0);

    do_read(8'h00, "R7 reset pointer");                 // pointer 0 -> reg0

    do_write(8'h11, 1'b1, 8'hA5, "R5 write reg1");
    chk("R5 reg1 updated", regs, 32'h0000A500);

    do_write(8'h01, 1'b0, 8'h00, "R4 pointer only");
    do_read(8'hA5, "R6 read reg1");
    do_read(8'hA5, "R7 reuse pointer");

    // foreign address
    bus_start();
    send_byte({7'h4D, 1'b0}, a); chk("R3 foreign addr nack", 32'(a), 32'd0);
    send_byte(8'h10, a);         chk("R3 foreign byte nack", 32'(a), 32'd0);
    send_byte(8'h99, a);
    bus_stop();
    chk("R3 foreign no change", regs, 32'h0000A500);

    // bytes without a start
    send_byte({MY, 1'b0}, a);    chk("R1 no start no ack", 32'(a), 32'd0);
    chk("R1 idle not driving", 32'(sda_oe), 32'd0);

    stat = 16'h3C5A;
    do_write(8'h09, 1'b0, 8'h00, "R6 ptr status");
    do_read(8'h3C, "R6 status byte1");
    do_write(8'h08, 1'b0, 8'h00, "R6 ptr status0");
    do_read(8'h5A, "R6 status byte0");

    do_write(8'h11, 1'b0, 8'h00, "R8 ptr waddr");
    do_read(8'hFF, "R8 write addr reads FF");

    do_write(8'h01, 1'b1, 8'h77, "R8 write to read addr");
    chk("R8 read addr not writable", regs, 32'h0000A500);

    // over-long write
    bus_start();
    send_byte({MY, 1'b0}, a);
    send_byte(8'h12, a);
    send_byte(8'h33, a);         chk("R10 second byte ack", 32'(a), 32'd1);
    send_byte(8'h44, a);         chk("R10 third byte nack", 32'(a), 32'd0);
    bus_stop();
    chk("R10 only second byte stored", regs, 32'h0033A500);

    // repeated start mid-byte
    bus_start();
    send_byte({MY, 1'b0}, a);
    send_byte(8'h13, a);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte({MY, 1'b0}, a);    chk("R9 addr ack after restart", 32'(a), 32'd1);
    send_byte(8'h13, a);
    send_byte(8'h5E, a);         chk("R9 data ack after restart", 32'(a), 32'd1);
    bus_stop();
    chk("R9 write after restart", regs, 32'h5E33A500);

    // master acks a read: slave still releases
    do_write(8'h03, 1'b0, 8'h00, "R11 ptr");
    bus_start();
    send_byte({MY, 1'b1}, a);
    exp_q.push_back('{val: 8'h5E, req: "R11 read with master ack"});
    recv_byte(1'b0, b);
    obs_q.push_back(b);
    chk("R11 released after master ack", 32'(sda_oe), 32'd0);
    bus_stop();

    wait (exp_q.size() == 0);
    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule